// File: doc/BRIEF.md
# Banked GPIO Controller with Edge Detection

This block is a memory-mapped general-purpose I/O controller. Its pins are grouped into banks of 32, and each bank holds a full set of registers:
- an output latch, changed only through write-one set and write-one clear registers;
- a direction register;
- rising and falling edge enables;
- a sticky edge-status register that software clears by writing ones;
- an interrupt mask.

Pin inputs pass through a two-flop synchronizer. Edges are found by comparing the synchronized level with its previous sample. The status bits, gated by each bank's mask, are ORed into one interrupt line.

Software uses it over a simple synchronous register bus. A write takes effect on the clock edge where `bus_wr` is sampled high. Read data is registered and appears one cycle after `bus_rd`. The number of banks (one to six) and the total pin count are parameters, so the last bank may be partial. A parameter vector marks the pins whose direction bit has the opposite polarity.

Top module: `gpio_banked_ctrl`

## Requirements
- R1: Byte address bit 8 selects the bank window: banks 0 to 2 use window 0 and banks 3 to 5 use window 1. Within a window, the bank slot s (0 to 2) adds 4*s to a register base:
  - level 0x00, direction 0x0C, set 0x18, clear 0x24;
  - rising enable 0x30, falling enable 0x3C, edge status 0x48;
  - interrupt mask 0x9C.

  In this list order the registers are called kinds 0 to 7. An address that hits no register, or hits a bank above the built count, reads zero and writes nothing.
- R2: Writing the set register raises every output bit written as one. Bits written as zero keep their value. The set register reads as zero.
- R3: Writing the clear register lowers every output bit written as one. Bits written as zero keep their value. The clear register reads as zero.
- R4: The direction register reads back as written. For a normal pin, 1 enables the output driver. For a pin marked in the inversion vector, 0 enables the driver.
- R5: The level register returns each pin input after two synchronizer flops.
- R6: Each pin has independent rising and falling enables; with both set, any transition is recorded. A status bit sets on the third rising clock edge after its pin changes.
- R7: A status bit stays set until a one is written to its position in the status register. Zero bits have no effect, and writing all ones clears the whole bank.
- R8: When a new edge and a clearing write meet the same status bit in the same cycle, the bit stays set.
- R9: The interrupt output is high exactly when some status bit has its mask bit set. The mask reads back as written.
- R10: Bit positions at or above the pin count in the last bank read as zero in every register, ignore writes and never record edges.
- R11: After reset, all outputs, directions, enables, status bits and masks are zero. Only inverted pins drive, and the interrupt is low.
- R12: `bus_rdata` changes only on the clock edge after a cycle with `bus_rd` high, and holds otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 9 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pin_in | input | NPINS | Asynchronous pin inputs |
| pin_out | output | NPINS | Output latch values |
| pin_oe | output | NPINS | Output driver enables |
| irq | output | 1 | Combined masked edge interrupt |

## Verification
The bench builds the block with four banks and 100 pins. This places bank 3 in the upper address window and leaves it with only four live pins, so both the split map and the partial-bank masking are reached. The inversion vector marks pins 86 to 89 in bank 2, so the reversed direction sense shows up on both the output enables and the reset state. Reads aimed at bank 4 fall on a bank slot that is not built.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

  localparam int GPIO_AW   = 9;
  localparam int BANK_W    = 32;
  localparam int MAX_BANKS = 6;
  localparam int KIND_STEP = 12;
  localparam int MASK_BASE = 156;

  typedef enum logic [2:0] {
    K_LEVEL = 3'd0,
    K_DIR   = 3'd1,
    K_SET   = 3'd2,
    K_CLR   = 3'd3,
    K_RISE  = 3'd4,
    K_FALL  = 3'd5,
    K_STAT  = 3'd6,
    K_MASK  = 3'd7
  } reg_kind_e;

  typedef struct packed {
    logic      hit;
    reg_kind_e kind;
    logic [2:0] bank;
  } dec_t;

  // Split map: bit 8 picks the window, the low byte picks kind and slot.
  function automatic dec_t gpio_decode(input logic [GPIO_AW-1:0] a, input int nbanks);
    dec_t d;
    int off;
    int slot;
    int bank;
    d = '0;
    d.kind = K_LEVEL;
    off = int'(a[7:0]);
    slot = 0;
    if (a[1:0] == 2'b00) begin
      if (off < 7 * KIND_STEP) begin
        d.kind = reg_kind_e'(3'(off / KIND_STEP));
        slot = (off % KIND_STEP) / 4;
        d.hit = 1'b1;
      end else if (off >= MASK_BASE && off < MASK_BASE + KIND_STEP) begin
        d.kind = K_MASK;
        slot = (off - MASK_BASE) / 4;
        d.hit = 1'b1;
      end
    end
    bank = a[8] ? 3 + slot : slot;
    d.bank = 3'(bank);
    if (bank >= nbanks) d.hit = 1'b0;
    return d;
  endfunction

  // Implemented-bit mask of one bank given the total pin count.
  function automatic logic [BANK_W-1:0] bank_impl(input int bank, input int npins);
    int lo;
    lo = bank * BANK_W;
    if (npins >= lo + BANK_W) return '1;
    else if (npins <= lo) return '0;
    else return (BANK_W'(1) << (npins - lo)) - BANK_W'(1);
  endfunction

  function automatic logic [BANK_W-1:0] edge_hits(
    input logic [BANK_W-1:0] cur,
    input logic [BANK_W-1:0] prev,
    input logic [BANK_W-1:0] rise_en,
    input logic [BANK_W-1:0] fall_en);
    return (cur & ~prev & rise_en) | (~cur & prev & fall_en);
  endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] d_sync
);

  logic [W-1:0] stage1;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1 <= '0;
      d_sync <= '0;
    end else begin
      stage1 <= d_async;
      d_sync <= stage1;
    end
  end

endmodule

// File: rtl/gpio_edge.sv
module gpio_edge
  import gpio_bank_pkg::*;
#(
  parameter logic [BANK_W-1:0] IMPL = '1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [BANK_W-1:0] lvl,
  input  logic [BANK_W-1:0] rise_en,
  input  logic [BANK_W-1:0] fall_en,
  input  logic [BANK_W-1:0] clr_bits,
  output logic [BANK_W-1:0] stat,
  output logic [BANK_W-1:0] ev
);

  logic [BANK_W-1:0] prev;

  assign ev = edge_hits(lvl, prev, rise_en, fall_en) & IMPL;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev <= '0;
      stat <= '0;
    end else begin
      prev <= lvl;
      // A fresh edge outranks a clearing write on the same bit.
      stat <= ((stat & ~clr_bits) | ev) & IMPL;
    end
  end

endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_bank_pkg::*;
#(
  parameter logic [BANK_W-1:0] IMPL = '1,
  parameter logic [BANK_W-1:0] INV  = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [7:0]        wsel,
  input  logic [BANK_W-1:0] wdata,
  input  reg_kind_e         rsel,
  input  logic [BANK_W-1:0] pad_in,
  output logic [BANK_W-1:0] out_q,
  output logic [BANK_W-1:0] oe,
  output logic [BANK_W-1:0] rd_word,
  output logic [BANK_W-1:0] stat,
  output logic [BANK_W-1:0] emask,
  output logic [BANK_W-1:0] ev,
  output logic [BANK_W-1:0] set_bits,
  output logic [BANK_W-1:0] clr_bits,
  output logic [BANK_W-1:0] stat_clr,
  output logic              irq_b
);

  logic [BANK_W-1:0] lvl;
  logic [BANK_W-1:0] dir_q;
  logic [BANK_W-1:0] rise_q;
  logic [BANK_W-1:0] fall_q;

  assign set_bits = wsel[K_SET]  ? (wdata & IMPL) : '0;
  assign clr_bits = wsel[K_CLR]  ? (wdata & IMPL) : '0;
  assign stat_clr = wsel[K_STAT] ? (wdata & IMPL) : '0;

  gpio_sync #(.W(BANK_W)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .d_async (pad_in),
    .d_sync  (lvl)
  );

  gpio_edge #(.IMPL(IMPL)) u_edge (
    .clk      (clk),
    .rst      (rst),
    .lvl      (lvl),
    .rise_en  (rise_q),
    .fall_en  (fall_q),
    .clr_bits (stat_clr),
    .stat     (stat),
    .ev       (ev)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_q  <= '0;
      dir_q  <= '0;
      rise_q <= '0;
      fall_q <= '0;
      emask  <= '0;
    end else begin
      out_q <= (out_q | set_bits) & ~clr_bits;
      if (wsel[K_DIR])  dir_q  <= wdata & IMPL;
      if (wsel[K_RISE]) rise_q <= wdata & IMPL;
      if (wsel[K_FALL]) fall_q <= wdata & IMPL;
      if (wsel[K_MASK]) emask  <= wdata & IMPL;
    end
  end

  assign oe    = (dir_q ^ INV) & IMPL;
  assign irq_b = |(stat & emask);

  always_comb begin
    case (rsel)
      K_LEVEL: rd_word = lvl & IMPL;
      K_DIR:   rd_word = dir_q;
      K_RISE:  rd_word = rise_q;
      K_FALL:  rd_word = fall_q;
      K_STAT:  rd_word = stat;
      K_MASK:  rd_word = emask;
      default: rd_word = '0;
    endcase
  end

endmodule

// File: rtl/gpio_banked_ctrl.sv
module gpio_banked_ctrl
  import gpio_bank_pkg::*;
#(
  parameter int NBANKS = 4,
  parameter int NPINS  = 100,
  parameter logic [MAX_BANKS*BANK_W-1:0] INV_PINS = {{(MAX_BANKS*BANK_W-4){1'b0}}, 4'hF} << 86
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic [GPIO_AW-1:0] bus_addr,
  input  logic [BANK_W-1:0]  bus_wdata,
  output logic [BANK_W-1:0]  bus_rdata,
  input  logic [NPINS-1:0]   pin_in,
  output logic [NPINS-1:0]   pin_out,
  output logic [NPINS-1:0]   pin_oe,
  output logic               irq
);

  localparam int TOTAL = NBANKS * BANK_W;

  dec_t dec;
  logic [TOTAL-1:0]  pad_all;
  logic [TOTAL-1:0]  out_all;
  logic [TOTAL-1:0]  oe_all;
  logic [TOTAL-1:0]  stat_all;
  logic [TOTAL-1:0]  emask_all;
  logic [TOTAL-1:0]  ev_all;
  logic [TOTAL-1:0]  out_set_all;
  logic [TOTAL-1:0]  out_clr_all;
  logic [TOTAL-1:0]  stat_clr_all;
  logic [NBANKS-1:0] irq_vec;
  logic [BANK_W-1:0] rd_words [NBANKS];
  logic [BANK_W-1:0] rd_sel;

  assign dec     = gpio_decode(bus_addr, NBANKS);
  assign pad_all = TOTAL'(pin_in);

  for (genvar b = 0; b < NBANKS; b++) begin : g_bank
    localparam logic [BANK_W-1:0] IMPL_B = bank_impl(b, NPINS);
    localparam logic [BANK_W-1:0] INV_B  = INV_PINS[b*BANK_W +: BANK_W];
    logic [7:0] wsel_b;

    assign wsel_b = (bus_wr && dec.hit && dec.bank == 3'(b)) ? (8'd1 << dec.kind) : 8'd0;

    gpio_bank #(.IMPL(IMPL_B), .INV(INV_B)) u_bank (
      .clk      (clk),
      .rst      (rst),
      .wsel     (wsel_b),
      .wdata    (bus_wdata),
      .rsel     (dec.kind),
      .pad_in   (pad_all[b*BANK_W +: BANK_W]),
      .out_q    (out_all[b*BANK_W +: BANK_W]),
      .oe       (oe_all[b*BANK_W +: BANK_W]),
      .rd_word  (rd_words[b]),
      .stat     (stat_all[b*BANK_W +: BANK_W]),
      .emask    (emask_all[b*BANK_W +: BANK_W]),
      .ev       (ev_all[b*BANK_W +: BANK_W]),
      .set_bits (out_set_all[b*BANK_W +: BANK_W]),
      .clr_bits (out_clr_all[b*BANK_W +: BANK_W]),
      .stat_clr (stat_clr_all[b*BANK_W +: BANK_W]),
      .irq_b    (irq_vec[b])
    );
  end

  always_comb begin
    rd_sel = '0;
    for (int b = 0; b < NBANKS; b++) begin
      if (dec.bank == 3'(b)) rd_sel = rd_words[b];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      bus_rdata <= dec.hit ? rd_sel : '0;
    end
  end

  assign pin_out = out_all[NPINS-1:0];
  assign pin_oe  = oe_all[NPINS-1:0];
  assign irq     = |irq_vec;

endmodule

// File: rtl/gpio_banked_ctrl_chk.sv
module gpio_banked_ctrl_chk #(
  parameter int TOTAL = 128
) (
  input logic             clk,
  input logic             rst,
  input logic             bus_rd,
  input logic [31:0]      bus_rdata,
  input logic             irq,
  input logic [TOTAL-1:0] out_all,
  input logic [TOTAL-1:0] oe_all,
  input logic [TOTAL-1:0] stat_all,
  input logic [TOTAL-1:0] emask_all,
  input logic [TOTAL-1:0] ev_all,
  input logic [TOTAL-1:0] out_set_all,
  input logic [TOTAL-1:0] out_clr_all,
  input logic [TOTAL-1:0] stat_clr_all
);

  // R2
  set_raises_chk: assert property (@(posedge clk) disable iff (rst)
    (|out_set_all) |=> ((out_all & $past(out_set_all)) == $past(out_set_all)));

  // R3
  clr_lowers_chk: assert property (@(posedge clk) disable iff (rst)
    (|out_clr_all) |=> ((out_all & $past(out_clr_all)) == '0));

  // R7
  status_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((stat_all & $past(stat_all & ~stat_clr_all)) == $past(stat_all & ~stat_clr_all)));

  // R8
  edge_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (|ev_all) |=> ((stat_all & $past(ev_all)) == $past(ev_all)));

  // R9
  irq_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    ((stat_all & emask_all) == '0) |-> !irq);

  // R12
  rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> $stable(bus_rdata));

endmodule

bind gpio_banked_ctrl gpio_banked_ctrl_chk #(.TOTAL(NBANKS * 32)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .bus_rd       (bus_rd),
  .bus_rdata    (bus_rdata),
  .irq          (irq),
  .out_all      (out_all),
  .oe_all       (oe_all),
  .stat_all     (stat_all),
  .emask_all    (emask_all),
  .ev_all       (ev_all),
  .out_set_all  (out_set_all),
  .out_clr_all  (out_clr_all),
  .stat_clr_all (stat_clr_all)
);

// File: tb/tb_gpio_banked_ctrl.sv
module tb_gpio_banked_ctrl;

  localparam int NB = 4;
  localparam int NP = 100;
  localparam logic [191:0] INV = {188'd0, 4'hF} << 86;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          bus_wr = 1'b0;
  logic          bus_rd = 1'b0;
  logic [8:0]    bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [NP-1:0] pin_in = '0;
  logic [NP-1:0] pin_out;
  logic [NP-1:0] pin_oe;
  logic          irq;

  always #5 clk = ~clk;

  gpio_banked_ctrl #(.NBANKS(NB), .NPINS(NP), .INV_PINS(INV)) dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
  );

  int n_cmp = 0;
  int n_bad = 0;
  logic [31:0]  m_out [NB];
  logic [31:0]  m_dir [NB];
  logic [31:0]  m_rise[NB];
  logic [31:0]  m_fall[NB];
  logic [31:0]  m_stat[NB];
  logic [31:0]  m_mask[NB];
  logic [127:0] pins_m = '0;

  function automatic logic [31:0] impl_of(input int b);
    int live;
    live = NP - b * 32;
    if (live >= 32) return 32'hFFFF_FFFF;
    if (live <= 0) return 32'h0;
    return (32'h1 << live) - 32'h1;
  endfunction

  // Kinds: 0 level,1 dir,2 set,3 clear,4 rise,5 fall,6 status,7 mask.
  function automatic logic [8:0] addr_of(input int kind, input int b);
    int koff;
    int base;
    koff = (kind < 7) ? kind * 12 : 156;
    base = (b < 3) ? b * 4 : 256 + (b - 3) * 4;
    return 9'(base + koff);
  endfunction

  function automatic logic [31:0] exp_read(input int kind, input int b);
    if (b >= NB) return 32'h0;
    case (kind)
      0: return pins_m[b*32 +: 32] & impl_of(b);
      1: return m_dir[b];
      4: return m_rise[b];
      5: return m_fall[b];
      6: return m_stat[b];
      7: return m_mask[b];
      default: return 32'h0;
    endcase
  endfunction

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_pins(input string req);
    logic [127:0] eo;
    logic [127:0] ee;
    logic         ei;
    eo = '0; ee = '0; ei = 1'b0;
    for (int b = 0; b < NB; b++) begin
      eo[b*32 +: 32] = m_out[b];
      ee[b*32 +: 32] = (m_dir[b] ^ INV[b*32 +: 32]) & impl_of(b);
      ei = ei | (|(m_stat[b] & m_mask[b]));
    end
    check({req, " pin_out"}, 128'(pin_out), eo);
    check({req, " pin_oe"}, 128'(pin_oe), ee);
    check({req, " irq"}, 128'(irq), 128'(ei));
  endtask

  task automatic bus_write(input logic [8:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [8:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic model_write(input int kind, input int b, input logic [31:0] w);
    if (b >= NB) return;
    case (kind)
      1: m_dir[b]  = w & impl_of(b);
      2: m_out[b]  = (m_out[b] | w) & impl_of(b);
      3: m_out[b]  = m_out[b] & ~w;
      4: m_rise[b] = w & impl_of(b);
      5: m_fall[b] = w & impl_of(b);
      6: m_stat[b] = m_stat[b] & ~w;
      7: m_mask[b] = w & impl_of(b);
      default: ;
    endcase
  endtask

  task automatic wr(input int kind, input int b, input logic [31:0] w);
    bus_write(addr_of(kind, b), w);
    model_write(kind, b, w);
  endtask

  task automatic rd_chk(input string req, input int kind, input int b);
    logic [31:0] d;
    bus_read(addr_of(kind, b), d);
    check(req, 128'(d), 128'(exp_read(kind, b)));
  endtask

  task automatic change_pins(input logic [127:0] nw_in);
    logic [127:0] nw;
    logic [31:0]  cur;
    logic [31:0]  prv;
    nw = nw_in & ((128'd1 << NP) - 128'd1);
    @(negedge clk);
    pin_in = nw[NP-1:0];
    repeat (4) @(negedge clk);
    for (int b = 0; b < NB; b++) begin
      cur = nw[b*32 +: 32];
      prv = pins_m[b*32 +: 32];
      m_stat[b] = m_stat[b] | (((cur & ~prv & m_rise[b]) | (~cur & prv & m_fall[b])) & impl_of(b));
    end
    pins_m = nw;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic [31:0] keep;
    void'($urandom(32'd7331));
    for (int b = 0; b < NB; b++) begin
      m_out[b] = '0; m_dir[b] = '0; m_rise[b] = '0;
      m_fall[b] = '0; m_stat[b] = '0; m_mask[b] = '0;
    end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R11 reset state
    check_pins("R11");
    check("R11 oe inverted pins", 128'(pin_oe), 128'(INV[NP-1:0]));
    for (int b = 0; b < NB; b++) begin
      rd_chk("R11 dir", 1, b);
      rd_chk("R11 status", 6, b);
      rd_chk("R11 mask", 7, b);
    end

    // R1 split map: bank 3 in the upper window, bank 4 absent
    wr(1, 3, 32'h0000_0003);
    bus_read(9'h10C, d);
    check("R1 bank3 dir at 0x10C", 128'(d), 128'h3);
    bus_write(9'h110, 32'hFFFF_FFFF);
    bus_read(9'h110, d);
    check("R1 absent bank reads zero", 128'(d), 128'h0);
    bus_write(9'h0A0, 32'h1234_5678);
    model_write(7, 1, 32'h1234_5678);
    bus_read(9'h0A0, d);
    check("R1 R9 bank1 mask readback", 128'(d), 128'h1234_5678);
    bus_read(9'h002, d);
    check("R1 misaligned reads zero", 128'(d), 128'h0);

    // R10 partial last bank
    wr(1, 3, 32'hFFFF_FFFF);
    rd_chk("R10 dir masked", 1, 3);
    check("R10 dir value", 128'(exp_read(1, 3)), 128'hF);
    wr(2, 3, 32'hFFFF_FFFF);
    check_pins("R10");
    wr(3, 3, 32'hFFFF_FFFF);

    // R2 R3 set/clear
    wr(2, 0, 32'h0000_00A5);
    check_pins("R2");
    rd_chk("R2 set reads zero", 2, 0);
    wr(3, 0, 32'h0000_0005);
    check_pins("R3");
    check("R3 value", 128'(pin_out[7:0]), 128'hA0);
    rd_chk("R3 clear reads zero", 3, 0);

    // R4 direction with inversion
    wr(1, 2, 32'h0040_0001);
    check_pins("R4");
    check("R4 inverted pin86 off", 128'(pin_oe[86]), 128'h0);
    check("R4 normal pin64 on", 128'(pin_oe[64]), 128'h1);
    rd_chk("R4 dir readback", 1, 2);

    // R5 level
    change_pins(128'h0000_0000_0000_00F0_0000_0000_DEAD_BEEF);
    rd_chk("R5 level bank0", 0, 0);
    rd_chk("R5 level bank2", 0, 2);

    // R6 independent enables
    wr(4, 0, 32'h2);
    wr(5, 0, 32'h4);
    wr(7, 0, 32'hFFFF_FFFF);
    change_pins(pins_m & ~128'h6);
    rd_chk("R6 fall only", 6, 0);
    check("R6 status", 128'(m_stat[0] & 32'h6), 128'h4);
    change_pins(pins_m | 128'h6);
    rd_chk("R6 rise only", 6, 0);
    check_pins("R9 irq");

    // R7 partial then full clear
    wr(6, 0, 32'h2);
    rd_chk("R7 partial clear", 6, 0);
    wr(6, 0, 32'hFFFF_FFFF);
    rd_chk("R7 full clear", 6, 0);
    check_pins("R7 irq low");

    // R8 edge and clear in the same cycle
    wr(4, 0, 32'h1);
    wr(5, 0, 32'h1);
    change_pins(pins_m & ~128'h1);
    change_pins(pins_m | 128'h1);
    @(negedge clk);
    pin_in[0] = 1'b0;
    @(negedge clk);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = addr_of(6, 0); bus_wdata = 32'h1;
    @(negedge clk);
    bus_wr = 1'b0;
    pins_m[0] = 1'b0;
    m_stat[0] = m_stat[0] | 32'h1;
    rd_chk("R8 edge beats clear", 6, 0);

    // R9 mask gating
    wr(7, 0, 32'h0);
    check_pins("R9 masked");
    wr(7, 0, 32'h1);
    check_pins("R9 unmasked");
    check("R9 irq high", 128'(irq), 128'h1);

    // R12 read data holds without a read
    bus_read(addr_of(1, 2), keep);
    wr(1, 2, 32'h0);
    check("R12 rdata held", 128'(bus_rdata), 128'(keep));

    // Random mix
    for (int it = 0; it < 400; it++) begin
      int op;
      int b;
      int k;
      logic [31:0]  w;
      logic [127:0] fl;
      op = int'($urandom_range(0, 6));
      b  = int'($urandom_range(0, NB - 1));
      w  = $urandom();
      case (op)
        0: wr(2, b, w);
        1: wr(3, b, w);
        2: wr(1, b, w);
        3: wr(int'($urandom_range(4, 5)), b, w);
        4: begin
          fl = {$urandom(), $urandom(), $urandom(), $urandom()} &
               {$urandom(), $urandom(), $urandom(), $urandom()};
          change_pins(pins_m ^ fl);
        end
        5: wr(int'($urandom_range(6, 7)), b, w);
        default: begin
          k = int'($urandom_range(0, 7));
          rd_chk("R1 random read", k, b);
        end
      endcase
      check_pins("R6 random");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule